// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls one port of general-purpose pins. Software reaches it over a simple register bus. For each pin it sets a data latch, a direction, a two-level function select, and pull resistor settings. From these the block produces the per-pin output value, output enable, pull-up and pull-down enables, and an input-gate control. The gate keeps the input paths closed until software opens them. Each pin drives one of four sources:

- its own data latch,
- peripheral A,
- peripheral B,
- an external memory bus, which takes over any function-selected pin while bus mode is active.

Pin levels pass through a synchronizer into a sample register, which software can read. A normal read of the data register returns either the pin level or the latch, depending on how the pin is configured. A read flagged as read-modify-write always returns the latch, so bit operations never copy pin levels into output latches.

Two low-power states are supported. In STOP, every pin holds its last driven state and keeps its pulls, and the input paths are closed. STOP with high-impedance also turns off every output driver and every pull. In both states, a pin that is function-selected and has its external interrupt enabled keeps its input open.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every register reads 0 and no pin drives: `pad_oe`, `pad_pu`, `pad_pd` and `pin_in_en` are all 0. The register addresses are: 0 data latch, 1 direction (1 = output), 2 function A select, 3 function B select, 4 pull enable, 5 pull direction, 6 pin sample (read-only), 7 control.
- R2: While control bit 0 (global input enable) is 0, `pin_in_en` is 0 and the sample register reads 0. Once the bit is set, the sample register reads the pin levels within four clocks of a pin change.
- R3: A read of address 6 returns the sampled pin levels whatever the direction bits are.
- R4: For a pin with function A select 0 and direction 0, a normal read of address 0 returns the sampled pin. A write to the latch changes only the latch, and the output enable stays 0.
- R5: For a pin with function A select 0 and direction 1, the output enable is 1, the latch drives the pin, and a normal read of address 0 returns the latch.
- R6: A read with `bus_rmw` set returns the data latch on every bit, whatever the direction and function bits are.
- R7: Function A=1 with B=0 drives peripheral A's value and enable. A=1 with B=1 drives peripheral B's. B=1 with A=0 acts as port mode. A normal data read of a function-selected pin returns the sampled pin.
- R8: While `ebus_mode` is 1, a pin with function A select 1 drives the external bus value and enable. A pin with function A select 0 stays in port mode.
- R9: The pull-up enable is (pull enable & pull direction) and the pull-down enable is (pull enable & ~pull direction), where direction 1 = up.
- R10: While `stop_req` is 1 and `stop_hiz` is 0:
  - output value and enable hold their values from the last clock before STOP, and pulls are kept;
  - `pin_in_en` is 1 only for pins with function A select 1 and `exti_en` set.
- R11: While `stop_req` and `stop_hiz` are both 1, every output enable and pull enable is 0, and `pin_in_en` follows the same interrupt exception as R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_rmw | input | 1 | Read belongs to a read-modify-write operation |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| pin_in | input | 8 | Pin levels from the pads |
| periph_a_out | input | 8 | Peripheral A output values |
| periph_a_oe | input | 8 | Peripheral A output enables |
| periph_b_out | input | 8 | Peripheral B output values |
| periph_b_oe | input | 8 | Peripheral B output enables |
| ebus_mode | input | 1 | External bus mode active |
| ebus_out | input | 8 | External bus output values |
| ebus_oe | input | 8 | External bus output enables |
| stop_req | input | 1 | STOP low-power state |
| stop_hiz | input | 1 | High-impedance variant of STOP |
| exti_en | input | 8 | External interrupt enable per pin |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pull-up enables |
| pad_pd | output | 8 | Pull-down enables |
| pin_in_en | output | 8 | Input path open per pin |

## Verification
The bench walks a table of source-select combinations:

- port input and port output,
- the B-only case that must fall back to port mode,
- peripherals A and B with differing values and enables,
- external bus mode with the function bit set and with it clear.

A design with the select priority wrong would drive the wrong peripheral or ignore the bus override.

Data reads are made on a mixed configuration where some pins are outputs and some are inputs or function-selected. A design that selects per register instead of per pin returns a wrong nibble, and a read-modify-write read that picks up pin levels shows up at once.

In STOP, the bench changes peripheral values and checks that the pads hold. A design that does not hold them, that drops pulls outside high-impedance mode, or that gates off the interrupt pin is caught there.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int REG_ADDR_W = 3;

   typedef enum logic [REG_ADDR_W-1:0] {
      RA_LATCH   = 3'd0,
      RA_DIR     = 3'd1,
      RA_FUNC_A  = 3'd2,
      RA_FUNC_B  = 3'd3,
      RA_PULL_EN = 3'd4,
      RA_PULL_UP = 3'd5,
      RA_SAMPLE  = 3'd6,
      RA_CTRL    = 3'd7
   } reg_addr_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin_i,
   input  logic [W-1:0] gate_i,
   output logic [W-1:0] sample_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= pin_i;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sample_o <= '0;
      else        sample_o <= stage_q[STAGES-1] & gate_i;

   // R2: a closed gate leaves a zero in the sample register
   a_r2_gated_sample_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(gate_i) == '0) |-> (sample_o == '0));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_port_pkg::*;
#(
   parameter int PINS   = 8,
   parameter int DATA_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_valid,
   input  logic                  bus_we,
   input  logic                  bus_rmw,
   input  logic [REG_ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic [PINS-1:0]       sample_i,
   output logic [PINS-1:0]       latch_o,
   output logic [PINS-1:0]       dir_o,
   output logic [PINS-1:0]       fa_o,
   output logic [PINS-1:0]       fb_o,
   output logic [PINS-1:0]       pen_o,
   output logic [PINS-1:0]       pup_o,
   output logic                  gpe_o
);
   if (PINS < 1 || PINS > DATA_W) begin : g_bad_pins
      $error("gpio_regs: PINS must lie in 1..DATA_W");
   end

   reg_addr_e addr;
   assign addr = reg_addr_e'(bus_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_o <= '0;
         dir_o   <= '0;
         fa_o    <= '0;
         fb_o    <= '0;
         pen_o   <= '0;
         pup_o   <= '0;
         gpe_o   <= 1'b0;
      end else if (bus_valid && bus_we) begin
         case (addr)
            RA_LATCH:   latch_o <= bus_wdata[PINS-1:0];
            RA_DIR:     dir_o   <= bus_wdata[PINS-1:0];
            RA_FUNC_A:  fa_o    <= bus_wdata[PINS-1:0];
            RA_FUNC_B:  fb_o    <= bus_wdata[PINS-1:0];
            RA_PULL_EN: pen_o   <= bus_wdata[PINS-1:0];
            RA_PULL_UP: pup_o   <= bus_wdata[PINS-1:0];
            RA_CTRL:    gpe_o   <= bus_wdata[0];
            default:    ;
         endcase
      end
   end

   // pins in port input or function mode report the pin level
   logic [PINS-1:0]   pin_view;
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      pin_view = fa_o | ~dir_o;
      rd_mux   = '0;
      case (addr)
         RA_LATCH:   rd_mux[PINS-1:0] = bus_rmw ? latch_o
                                       : ((sample_i & pin_view) | (latch_o & ~pin_view));
         RA_DIR:     rd_mux[PINS-1:0] = dir_o;
         RA_FUNC_A:  rd_mux[PINS-1:0] = fa_o;
         RA_FUNC_B:  rd_mux[PINS-1:0] = fb_o;
         RA_PULL_EN: rd_mux[PINS-1:0] = pen_o;
         RA_PULL_UP: rd_mux[PINS-1:0] = pup_o;
         RA_SAMPLE:  rd_mux[PINS-1:0] = sample_i;
         RA_CTRL:    rd_mux[0]        = gpe_o;
         default:    ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                     bus_rdata <= '0;
      else if (bus_valid && !bus_we)  bus_rdata <= rd_mux;

   // R6: a read-modify-write read returns the latch
   a_r6_rmw_reads_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_we && bus_rmw && bus_addr == RA_LATCH)
      |=> (bus_rdata[PINS-1:0] == $past(latch_o)));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
   parameter int PINS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PINS-1:0] latch_i,
   input  logic [PINS-1:0] dir_i,
   input  logic [PINS-1:0] fa_i,
   input  logic [PINS-1:0] fb_i,
   input  logic [PINS-1:0] pen_i,
   input  logic [PINS-1:0] pup_i,
   input  logic            gpe_i,
   input  logic [PINS-1:0] pa_out_i,
   input  logic [PINS-1:0] pa_oe_i,
   input  logic [PINS-1:0] pb_out_i,
   input  logic [PINS-1:0] pb_oe_i,
   input  logic            ebus_mode_i,
   input  logic [PINS-1:0] ebus_out_i,
   input  logic [PINS-1:0] ebus_oe_i,
   input  logic            stop_i,
   input  logic            hiz_i,
   input  logic [PINS-1:0] exti_en_i,
   output logic [PINS-1:0] pad_out_o,
   output logic [PINS-1:0] pad_oe_o,
   output logic [PINS-1:0] pad_pu_o,
   output logic [PINS-1:0] pad_pd_o,
   output logic [PINS-1:0] in_open_o
);
   logic hiz_act;
   assign hiz_act = stop_i & hiz_i;

   for (genvar i = 0; i < PINS; i++) begin : g_pin
      logic live_out, live_oe, hold_out, hold_oe;

      always_comb begin
         if (ebus_mode_i && fa_i[i]) begin
            live_out = ebus_out_i[i];
            live_oe  = ebus_oe_i[i];
         end else if (fa_i[i] && fb_i[i]) begin
            live_out = pb_out_i[i];
            live_oe  = pb_oe_i[i];
         end else if (fa_i[i]) begin
            live_out = pa_out_i[i];
            live_oe  = pa_oe_i[i];
         end else begin
            live_out = latch_i[i];
            live_oe  = dir_i[i];
         end
      end

      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) begin
            hold_out <= 1'b0;
            hold_oe  <= 1'b0;
         end else if (!stop_i) begin
            hold_out <= live_out;
            hold_oe  <= live_oe;
         end

      assign pad_out_o[i] = stop_i ? hold_out : live_out;
      assign pad_oe_o[i]  = stop_i ? (hold_oe & ~hiz_i) : live_oe;
      assign pad_pu_o[i]  = pen_i[i] &  pup_i[i] & ~hiz_act;
      assign pad_pd_o[i]  = pen_i[i] & ~pup_i[i] & ~hiz_act;
      assign in_open_o[i] = gpe_i & (~stop_i | (fa_i[i] & exti_en_i[i]));

      // R10: pad value frozen across consecutive STOP cycles
      a_r10_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
         (stop_i && $past(stop_i)) |-> $stable(pad_out_o[i]));
   end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_port_pkg::*;
#(
   parameter int PINS        = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_valid,
   input  logic                  bus_we,
   input  logic                  bus_rmw,
   input  logic [REG_ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic [PINS-1:0]       pin_in,
   input  logic [PINS-1:0]       periph_a_out,
   input  logic [PINS-1:0]       periph_a_oe,
   input  logic [PINS-1:0]       periph_b_out,
   input  logic [PINS-1:0]       periph_b_oe,
   input  logic                  ebus_mode,
   input  logic [PINS-1:0]       ebus_out,
   input  logic [PINS-1:0]       ebus_oe,
   input  logic                  stop_req,
   input  logic                  stop_hiz,
   input  logic [PINS-1:0]       exti_en,
   output logic [PINS-1:0]       pad_out,
   output logic [PINS-1:0]       pad_oe,
   output logic [PINS-1:0]       pad_pu,
   output logic [PINS-1:0]       pad_pd,
   output logic [PINS-1:0]       pin_in_en
);
   logic [PINS-1:0] sample, latch, dir, fa, fb, pen, pup;
   logic            gpe;

   gpio_in_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_in), .gate_i(pin_in_en), .sample_o(sample)
   );

   gpio_regs #(.PINS(PINS), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
      .bus_rmw(bus_rmw), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .sample_i(sample), .latch_o(latch), .dir_o(dir),
      .fa_o(fa), .fb_o(fb), .pen_o(pen), .pup_o(pup), .gpe_o(gpe)
   );

   gpio_pin_mux #(.PINS(PINS)) u_mux (
      .clk(clk), .rst_n(rst_n), .latch_i(latch), .dir_i(dir), .fa_i(fa), .fb_i(fb),
      .pen_i(pen), .pup_i(pup), .gpe_i(gpe), .pa_out_i(periph_a_out),
      .pa_oe_i(periph_a_oe), .pb_out_i(periph_b_out), .pb_oe_i(periph_b_oe),
      .ebus_mode_i(ebus_mode), .ebus_out_i(ebus_out), .ebus_oe_i(ebus_oe),
      .stop_i(stop_req), .hiz_i(stop_hiz), .exti_en_i(exti_en),
      .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_pu_o(pad_pu),
      .pad_pd_o(pad_pd), .in_open_o(pin_in_en)
   );

   // R11: high-impedance STOP releases every driver and pull
   a_r11_hiz_release: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && stop_hiz) |-> (pad_oe == '0 && pad_pu == '0 && pad_pd == '0));

   // R5: port-mode pins take their enable from the direction register
   a_r5_port_oe_dir: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_req) |-> ((pad_oe & ~fa) == (dir & ~fa)));
endmodule

// File: tb/gpio_port_ctrl_bench.sv
module gpio_port_ctrl_bench;
   localparam int PINS = 8;
   localparam int NV   = 11;

   // fields: [16:13] requirement, [12] fa, [11] fb, [10] dir, [9] latch,
   // [8] pa_out, [7] pa_oe, [6] pb_out, [5] pb_oe, [4] ebus_mode,
   // [3] ebus_out, [2] ebus_oe, [1] expected out, [0] expected oe
   localparam logic [16:0] VEC [NV] = '{
      17'b0100_0001_1100_000_10,   // R4 port input
      17'b0101_0011_0000_000_11,   // R5 port output high
      17'b0101_0010_0000_000_01,   // R5 port output low
      17'b0111_0111_0000_000_11,   // R7 B alone = port mode
      17'b0111_1000_1100_000_11,   // R7 peripheral A
      17'b0111_1000_0111_000_01,   // R7 peripheral A, B ignored
      17'b0111_1100_1110_000_10,   // R7 peripheral B
      17'b0111_1100_0011_000_11,   // R7 peripheral B driving
      17'b1000_1000_0000_111_11,   // R8 bus over function pin
      17'b1000_0010_0000_111_01,   // R8 port pin ignores bus
      17'b1000_1100_0011_101_01    // R8 bus beats peripheral B
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_valid = 0, bus_we = 0, bus_rmw = 0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic [PINS-1:0] pin_in = '0, pa_out = '0, pa_oe = '0, pb_out = '0, pb_oe = '0;
   logic ebus_mode = 0, stop_req = 0, stop_hiz = 0;
   logic [PINS-1:0] ebus_out = '0, ebus_oe = '0, exti_en = '0;
   logic [PINS-1:0] pad_out, pad_oe, pad_pu, pad_pd, pin_in_en;

   int checks = 0, fails = 0;
   bit done = 0;
   logic [7:0] rd;

   always #10 clk = ~clk;

   gpio_port_ctrl u_gpio_port_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
      .bus_rmw(bus_rmw), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .pin_in(pin_in), .periph_a_out(pa_out),
      .periph_a_oe(pa_oe), .periph_b_out(pb_out), .periph_b_oe(pb_oe),
      .ebus_mode(ebus_mode), .ebus_out(ebus_out), .ebus_oe(ebus_oe),
      .stop_req(stop_req), .stop_hiz(stop_hiz), .exti_en(exti_en),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
      .pin_in_en(pin_in_en)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_valid = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 0; bus_we = 0;
   endtask

   task automatic rdr(input logic [2:0] a, input logic rmw, output logic [7:0] d);
      @(negedge clk);
      bus_valid = 1; bus_we = 0; bus_rmw = rmw; bus_addr = a;
      @(negedge clk);
      bus_valid = 0; bus_rmw = 0;
      d = bus_rdata;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 pad_oe", pad_oe, 8'h00);
      chk("R1 pulls", pad_pu | pad_pd, 8'h00);
      chk("R1 pin_in_en", pin_in_en, 8'h00);
      rdr(3'd1, 0, rd); chk("R1 dir reg", rd, 8'h00);
      rdr(3'd7, 0, rd); chk("R1 ctrl reg", rd, 8'h00);

      // R2 inputs gated until enable
      pin_in = 8'hA5;
      repeat (4) @(negedge clk);
      rdr(3'd6, 0, rd); chk("R2 gated sample", rd, 8'h00);
      chk("R2 gate closed", pin_in_en, 8'h00);
      wr(3'd7, 8'h01);
      repeat (4) @(negedge clk);
      chk("R2 gate open", pin_in_en, 8'hFF);
      rdr(3'd6, 0, rd); chk("R2 sample after enable", rd, 8'hA5);

      // R3 sample independent of direction
      wr(3'd1, 8'hFF);
      rdr(3'd6, 0, rd); chk("R3 sample with outputs", rd, 8'hA5);

      // R4 input mode read and latch-only write
      wr(3'd1, 8'h00);
      wr(3'd0, 8'h3C);
      chk("R4 oe stays off", pad_oe, 8'h00);
      rdr(3'd0, 0, rd); chk("R4 data reads pin", rd, 8'hA5);

      // R5 mixed direction
      wr(3'd1, 8'hF0);
      rdr(3'd0, 0, rd); chk("R5 mixed data read", rd, 8'h35);
      chk("R5 pad_out latch", pad_out & 8'hF0, 8'h30);

      // R6 rmw read
      rdr(3'd0, 1, rd); chk("R6 rmw read", rd, 8'h3C);

      // R7 function pins read pin level
      wr(3'd1, 8'hFF);
      wr(3'd2, 8'h0F);
      rdr(3'd0, 0, rd); chk("R7 function pin read", rd, 8'h35);
      rdr(3'd0, 1, rd); chk("R6 rmw read func", rd, 8'h3C);

      // vector table walk for R4, R5, R7, R8
      for (int i = 0; i < NV; i++) begin
         logic [16:0] v;
         v = VEC[i];
         wr(3'd0, {8{v[9]}});
         wr(3'd1, {8{v[10]}});
         wr(3'd2, {8{v[12]}});
         wr(3'd3, {8{v[11]}});
         @(negedge clk);
         pa_out = {8{v[8]}}; pa_oe = {8{v[7]}};
         pb_out = {8{v[6]}}; pb_oe = {8{v[5]}};
         ebus_mode = v[4]; ebus_out = {8{v[3]}}; ebus_oe = {8{v[2]}};
         @(negedge clk);
         chk($sformatf("R%0d vec%0d out", v[16:13], i), pad_out, {8{v[1]}});
         chk($sformatf("R%0d vec%0d oe", v[16:13], i), pad_oe, {8{v[0]}});
      end
      ebus_mode = 0;

      // R9 pulls
      wr(3'd4, 8'hF0);
      wr(3'd5, 8'hCC);
      chk("R9 pull-up", pad_pu, 8'hC0);
      chk("R9 pull-down", pad_pd, 8'h30);

      // R10 STOP hold
      wr(3'd0, 8'h3C);
      wr(3'd1, 8'hFF);
      wr(3'd2, 8'h01);
      wr(3'd3, 8'h00);
      @(negedge clk);
      pa_out = 8'hFF; pa_oe = 8'hFF; exti_en = 8'h01;
      @(negedge clk);
      chk("R7 pre-stop out", pad_out, 8'h3D);
      stop_req = 1;
      @(negedge clk);
      pa_out = 8'h00; pa_oe = 8'h00;
      repeat (2) @(negedge clk);
      chk("R10 out held", pad_out, 8'h3D);
      chk("R10 oe held", pad_oe, 8'hFF);
      chk("R10 pulls kept", pad_pu | pad_pd, 8'hF0);
      chk("R10 input gate", pin_in_en, 8'h01);

      // R11 STOP-HIZ
      stop_hiz = 1;
      @(negedge clk);
      chk("R11 oe off", pad_oe, 8'h00);
      chk("R11 pulls off", pad_pu | pad_pd, 8'h00);
      chk("R11 input gate", pin_in_en, 8'h01);
      stop_hiz = 0; stop_req = 0;
      @(negedge clk);
      chk("R10 exit live", pad_out, 8'h3C);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule